// File: doc/BRIEF.md
# TLB Access Permission Checker

This block follows a translation lookup that has already found an address match. Each time the lookup presents a matching entry, the checker compares the entry's valid flag, its written-since-load (dirty) flag and its two-bit protection code against the kind of access (load or store) and the current privilege level. It then decides one of two things in the next clock cycle. Either the access is granted, or exactly one memory-management exception is taken.

When an exception is taken, the block records the complete faulting virtual address. It also records the page-number half of the page-table-entry-high image together with the address-space identifier that was current at the time, and the way index that matched. For the exception entry it saves the program counter and status word of the faulting instruction, and it builds the new status word with the block, mode and bank bits forced to 1. It presents the handler address as the vector base plus 0x100. The lookup itself, miss handling, refill and the pipeline that uses these results are outside this block.

Top module: `tlb_access_guard`

## Requirements
- R1: A strobed access to an entry whose valid flag is 0 raises the invalid-entry fault, with code 0x040 for a load and 0x060 for a store.
- R2: The protection code allows the following. In privileged mode, codes 00 and 10 allow loads only, and codes 01 and 11 allow loads and stores. In user mode, codes 00 and 01 allow nothing, code 10 allows loads only, and code 11 allows both. A disallowed access raises the protection fault, with code 0x0A0 for a load and 0x0C0 for a store.
- R3: A store that passes the valid and protection checks but hits an entry whose dirty flag is 0 raises the first-write fault with code 0x080.
- R4: Only one fault is raised per access. The checks are ranked with invalid entry first, protection second and dirty flag last.
- R5: On a fault, the fault-address register takes the full 32-bit virtual address of the access.
- R6: On a fault, the page-table-high register takes VA[31:10] in bits 31:10, zeros in bits 9:8 and the current ASID in bits 7:0.
- R7: On a fault, the way-index register takes the index of the way that matched.
- R8: On a fault, the saved-PC and saved-SR registers take the access's PC and SR. The new-SR output equals the old SR with bits 28 (BL), 29 (RB) and 30 (MD) set to 1. The vector output equals VBR + 0x100.
- R9: An access that passes every check pulses the grant output and leaves all captured registers and the code register unchanged.
- R10: The grant and fault outputs are single-cycle pulses in the cycle after the strobe, and exactly one of them pulses for each strobe.
- R11: In a cycle with no strobe, grant and fault stay low and every captured register holds its value, whatever the other inputs do.
- R12: A synchronous reset clears every output and register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_vld | input | 1 | Lookup matched; entry and access fields are valid |
| ent_valid | input | 1 | Entry valid flag |
| ent_dirty | input | 1 | Entry dirty flag |
| ent_prot | input | 2 | Entry protection code |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| priv_mode | input | 1 | 1 when privileged |
| acc_va | input | 32 | Virtual address of the access |
| cur_asid | input | 8 | Current address-space identifier |
| hit_way | input | 2 | Way that matched |
| cur_pc | input | 32 | PC of the accessing instruction |
| cur_sr | input | 32 | Status word of the accessing instruction |
| vbr | input | 32 | Vector base |
| grant | output | 1 | Access allowed (pulse) |
| fault | output | 1 | Exception taken (pulse) |
| exc_code | output | 12 | Event code of the last fault |
| fault_va | output | 32 | Captured faulting address |
| pteh | output | 32 | Page number and ASID image |
| way_idx | output | 2 | Captured way index |
| spc | output | 32 | Saved PC |
| ssr | output | 32 | Saved status word |
| sr_new | output | 32 | Status word for exception entry |
| vector | output | 32 | Handler address |

## Verification
The assertions assume that every entry field, the access attributes and the PC, SR and VBR values are settled whenever the strobe is high. They also assume that reset is applied before the first strobe. The bench drives all of these together at the falling edge, one access per strobe, and then keeps the strobe low for a cycle while it scrambles the other inputs. This idle cycle exposes any capture that does not depend on the strobe. The sweep covers every combination of valid, dirty, protection, direction and mode, so each rank of the priority order is reached with the lower-ranked conditions both true and false.

// File: rtl/tlb_access_guard.sv
module tlb_access_guard #(
  parameter int AW         = 32,
  parameter int ASID_W     = 8,
  parameter int WAY_W      = 2,
  parameter int PAGE_SHIFT = 10,
  parameter int CODE_W     = 12,
  parameter int SR_BL      = 28,
  parameter int SR_RB      = 29,
  parameter int SR_MD      = 30,
  parameter logic [AW-1:0] VEC_OFS = 32'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_vld,
  input  logic              ent_valid,
  input  logic              ent_dirty,
  input  logic [1:0]        ent_prot,
  input  logic              acc_write,
  input  logic              priv_mode,
  input  logic [AW-1:0]     acc_va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [AW-1:0]     cur_pc,
  input  logic [AW-1:0]     cur_sr,
  input  logic [AW-1:0]     vbr,
  output logic              grant,
  output logic              fault,
  output logic [CODE_W-1:0] exc_code,
  output logic [AW-1:0]     fault_va,
  output logic [AW-1:0]     pteh,
  output logic [WAY_W-1:0]  way_idx,
  output logic [AW-1:0]     spc,
  output logic [AW-1:0]     ssr,
  output logic [AW-1:0]     sr_new,
  output logic [AW-1:0]     vector
);
  localparam logic [CODE_W-1:0] C_INV_RD  = CODE_W'(12'h040);
  localparam logic [CODE_W-1:0] C_INV_WR  = CODE_W'(12'h060);
  localparam logic [CODE_W-1:0] C_DIRTY   = CODE_W'(12'h080);
  localparam logic [CODE_W-1:0] C_PROT_RD = CODE_W'(12'h0A0);
  localparam logic [CODE_W-1:0] C_PROT_WR = CODE_W'(12'h0C0);
  localparam int PAD_W = PAGE_SHIFT - ASID_W;
  localparam logic [AW-1:0] SR_SET = (AW'(1) << SR_BL) | (AW'(1) << SR_RB) | (AW'(1) << SR_MD);

  logic allow_rd, allow_wr;
  logic bad_inv, bad_prot, bad_dirty, any_bad;
  logic [CODE_W-1:0] code_sel;
  logic [AW-1:0] pteh_next;

  assign allow_rd  = priv_mode | ent_prot[1];
  assign allow_wr  = ent_prot[0] & allow_rd;
  assign bad_inv   = ~ent_valid;
  assign bad_prot  = acc_write ? ~allow_wr : ~allow_rd;
  assign bad_dirty = acc_write & ~ent_dirty;
  assign any_bad   = bad_inv | bad_prot | bad_dirty;
  assign pteh_next = {acc_va[AW-1:PAGE_SHIFT], {PAD_W{1'b0}}, cur_asid};

  always_comb begin
    if (bad_inv)
      code_sel = acc_write ? C_INV_WR : C_INV_RD;
    else if (bad_prot)
      code_sel = acc_write ? C_PROT_WR : C_PROT_RD;
    else
      code_sel = C_DIRTY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= 1'b0;
      fault    <= 1'b0;
      exc_code <= '0;
      fault_va <= '0;
      pteh     <= '0;
      way_idx  <= '0;
      spc      <= '0;
      ssr      <= '0;
      sr_new   <= '0;
      vector   <= '0;
    end else begin
      grant <= hit_vld & ~any_bad;
      fault <= hit_vld & any_bad;
      if (hit_vld && any_bad) begin
        exc_code <= code_sel;
        fault_va <= acc_va;
        pteh     <= pteh_next;
        way_idx  <= hit_way;
        spc      <= cur_pc;
        ssr      <= cur_sr;
        sr_new   <= cur_sr | SR_SET;
        vector   <= vbr + VEC_OFS;
      end
    end
  end
endmodule

// File: rtl/tlb_access_guard_chk.sv
module tlb_access_guard_chk #(
  parameter int AW = 32, parameter int ASID_W = 8, parameter int WAY_W = 2,
  parameter int CODE_W = 12, parameter int SR_BL = 28, parameter int SR_RB = 29,
  parameter int SR_MD = 30
) (
  input logic clk, input logic rst, input logic hit_vld,
  input logic ent_valid, input logic ent_dirty, input logic [1:0] ent_prot,
  input logic acc_write, input logic priv_mode,
  input logic [AW-1:0] acc_va, input logic [AW-1:0] vbr,
  input logic grant, input logic fault, input logic [CODE_W-1:0] exc_code,
  input logic [AW-1:0] fault_va, input logic [AW-1:0] pteh,
  input logic [WAY_W-1:0] way_idx, input logic [AW-1:0] spc,
  input logic [AW-1:0] ssr, input logic [AW-1:0] sr_new, input logic [AW-1:0] vector
);
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    hit_vld |=> (grant != fault));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !hit_vld |=> (!grant && !fault));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !hit_vld |=> ($stable(fault_va) && $stable(pteh) && $stable(way_idx) &&
                  $stable(spc) && $stable(ssr) && $stable(exc_code)));
  p_invalid_code_r1: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && !ent_valid) |=>
      (fault && exc_code == ($past(acc_write) ? CODE_W'(12'h060) : CODE_W'(12'h040))));
  p_user_none_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && ent_valid && !priv_mode && !ent_prot[1]) |=> fault);
  p_dirty_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && ent_valid && priv_mode && ent_prot[0] && acc_write && !ent_dirty) |=>
      (fault && exc_code == CODE_W'(12'h080)));
  p_grant_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    grant |-> ($stable(fault_va) && $stable(spc) && $stable(pteh) && $stable(vector)));
  p_va_capture_r5: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_va == $past(acc_va)));
  p_sr_bits_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (sr_new[SR_BL] && sr_new[SR_RB] && sr_new[SR_MD]));
  p_vector_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (vector == $past(vbr) + AW'(32'h100)));
endmodule

bind tlb_access_guard tlb_access_guard_chk #(
  .AW(AW), .ASID_W(ASID_W), .WAY_W(WAY_W), .CODE_W(CODE_W),
  .SR_BL(SR_BL), .SR_RB(SR_RB), .SR_MD(SR_MD)
) u_chk (
  .clk(clk), .rst(rst), .hit_vld(hit_vld), .ent_valid(ent_valid),
  .ent_dirty(ent_dirty), .ent_prot(ent_prot), .acc_write(acc_write),
  .priv_mode(priv_mode), .acc_va(acc_va), .vbr(vbr), .grant(grant),
  .fault(fault), .exc_code(exc_code), .fault_va(fault_va), .pteh(pteh),
  .way_idx(way_idx), .spc(spc), .ssr(ssr), .sr_new(sr_new), .vector(vector)
);

// File: tb/tb_tlb_access_guard.sv
module tb_tlb_access_guard;
  logic clk = 1'b0, rst = 1'b1;
  logic hit_vld = 0, ent_valid = 0, ent_dirty = 0, acc_write = 0, priv_mode = 0;
  logic [1:0] ent_prot = 0, hit_way = 0;
  logic [7:0] cur_asid = 0;
  logic [31:0] acc_va = 0, cur_pc = 0, cur_sr = 0, vbr = 0;
  logic grant, fault;
  logic [11:0] exc_code;
  logic [31:0] fault_va, pteh, spc, ssr, sr_new, vector;
  logic [1:0] way_idx;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [11:0] e_code = 0;
  logic [31:0] e_va = 0, e_pteh = 0, e_spc = 0, e_ssr = 0, e_srn = 0, e_vec = 0;
  logic [1:0] e_way = 0;

  always #5 clk = ~clk;

  tlb_access_guard dut (
    .clk(clk), .rst(rst), .hit_vld(hit_vld), .ent_valid(ent_valid),
    .ent_dirty(ent_dirty), .ent_prot(ent_prot), .acc_write(acc_write),
    .priv_mode(priv_mode), .acc_va(acc_va), .cur_asid(cur_asid),
    .hit_way(hit_way), .cur_pc(cur_pc), .cur_sr(cur_sr), .vbr(vbr),
    .grant(grant), .fault(fault), .exc_code(exc_code), .fault_va(fault_va),
    .pteh(pteh), .way_idx(way_idx), .spc(spc), .ssr(ssr), .sr_new(sr_new),
    .vector(vector)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk(req, "exc_code", 32'(exc_code), 32'(e_code));
    chk(req, "fault_va", fault_va, e_va);
    chk(req, "pteh", pteh, e_pteh);
    chk(req, "way_idx", 32'(way_idx), 32'(e_way));
    chk(req, "spc", spc, e_spc);
    chk(req, "ssr", ssr, e_ssr);
    chk(req, "sr_new", sr_new, e_srn);
    chk(req, "vector", vector, e_vec);
  endtask

  task automatic scramble(input int s);
    ent_valid = s[0]; ent_dirty = s[1]; ent_prot = 2'(s >> 2);
    acc_write = s[4]; priv_mode = s[5];
    acc_va   = 32'h9E37_79B9 * 32'(s + 1);
    cur_asid = 8'(s * 7 + 3);
    hit_way  = 2'(s) ^ 2'(s >> 4);
    cur_pc   = acc_va ^ 32'h1234_5678;
    cur_sr   = 32'h0000_00F0 ^ (32'(s) << 4) ^ (s[3] ? 32'h5000_0000 : 32'h0);
    vbr      = 32'h8000_0000 + 32'(s) * 32'h40;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "grant", 32'(grant), 0);
    chk("R12", "fault", 32'(fault), 0);
    check_regs("R12");
    rst = 0;
    for (int i = 0; i < 64; i++) begin
      logic f, rd_ok, wr_ok, b_inv, b_prot, b_dirty;
      string tag;
      int nb;
      scramble(i);
      hit_vld = 1;
      rd_ok  = priv_mode | ent_prot[1];
      wr_ok  = ent_prot[0] & rd_ok;
      b_inv   = !ent_valid;
      b_prot  = acc_write ? !wr_ok : !rd_ok;
      b_dirty = acc_write & !ent_dirty;
      f = b_inv | b_prot | b_dirty;
      nb = int'(b_inv) + int'(b_prot) + int'(b_dirty);
      tag = !f ? "R9" : (nb > 1) ? "R4" : b_inv ? "R1" : b_prot ? "R2" : "R3";
      if (f) begin
        // R4: rank invalid, then protection, then dirty
        if (b_inv)       e_code = acc_write ? 12'h060 : 12'h040;
        else if (b_prot) e_code = acc_write ? 12'h0C0 : 12'h0A0;
        else             e_code = 12'h080;
        e_va   = acc_va;
        e_pteh = {acc_va[31:10], 2'b00, cur_asid};
        e_way  = hit_way;
        e_spc  = cur_pc;
        e_ssr  = cur_sr;
        e_srn  = cur_sr | 32'h7000_0000;
        e_vec  = vbr + 32'h100;
      end
      @(negedge clk);
      hit_vld = 0;
      scramble(i ^ 6'h2A);
      chk("R10", "grant", 32'(grant), 32'(!f));
      chk("R10", "fault", 32'(fault), 32'(f));
      chk(tag, "exc_code", 32'(exc_code), 32'(e_code));
      chk(f ? "R5" : "R9", "fault_va", fault_va, e_va);
      chk(f ? "R6" : "R9", "pteh", pteh, e_pteh);
      chk(f ? "R7" : "R9", "way_idx", 32'(way_idx), 32'(e_way));
      chk(f ? "R8" : "R9", "spc", spc, e_spc);
      chk(f ? "R8" : "R9", "ssr", ssr, e_ssr);
      chk(f ? "R8" : "R9", "sr_new", sr_new, e_srn);
      chk(f ? "R8" : "R9", "vector", vector, e_vec);
      @(negedge clk);
      chk("R11", "grant", 32'(grant), 0);
      chk("R11", "fault", 32'(fault), 0);
      check_regs("R11");
    end
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R12", "fault", 32'(fault), 0);
    e_code = 0; e_va = 0; e_pteh = 0; e_way = 0; e_spc = 0; e_ssr = 0; e_srn = 0; e_vec = 0;
    check_regs("R12");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule